// File: doc/BRIEF.md
# Wave-Table Playback Voice

This block is one voice of a sound generator. It holds a sixteen-byte table of thirty-two four-bit samples and steps through them in a loop. The step rate is set by an eleven-bit rate value. Each four-bit sample can be passed through unchanged, scaled down by a right shift, or silenced. Software loads the table through a small byte port. A trigger pulse starts playback. An optional length counter, clocked by an external tick, stops the voice after a programmed number of ticks.

While the voice plays, the table is shared between playback and the byte port. The block reproduces that contention. Port access succeeds only in the single cycle in which playback reads the table. A restart that lands in that cycle corrupts the start of the table. After a restart, the first table read is delayed, and the voice first plays whatever the sample buffer already holds.

Top module: `wavetable_voice`

## Requirements
- R1: After reset the voice is inactive, `sample` is 0, and every table byte reads 0.
- R2: A trigger (`trig` high while `en` is high) sets `active` and resets the sample pointer to 0. The first fetch happens P+3 clocks after the trigger edge, where P = 2*(2048 - `rate`). Later fetches happen every P clocks. Each fetch advances the pointer by one and loads the byte at index pointer/2 into the sample buffer.
- R3: Samples come from the buffer. An even pointer plays bits 7:4 and an odd pointer plays bits 3:0. A trigger does not reload the buffer, so the old buffer's upper nibble plays until the first fetch. After that fetch, the low nibble of byte 0 plays.
- R4: With `level` 0 the output is 0 but the voice stays active. With `level` 1 the nibble is output unchanged. Level 2 shifts it right by 1, and level 3 shifts it right by 2.
- R5: With `en` low, the voice becomes inactive at the next edge and `sample` is 0. A `trig` while `en` is low is ignored.
- R6: While inactive, `cpu_rdata` shows the byte at `cpu_addr`, and a write with `cpu_we` stores to that address.
- R7: While active, `cpu_rdata` is 0xFF except in a fetch cycle. In a fetch cycle it shows the byte being fetched, whatever `cpu_addr` is, and a write goes to that byte. Writes outside fetch cycles are dropped.
- R8: A trigger in a fetch cycle corrupts the table, based on the pre-fetch byte index pointer/2. If that index is below 4, byte 0 receives the buffer. Otherwise bytes 0..3 receive the aligned group of four bytes that contains the index.
- R9: `len_load` sets the length count to 256 - `len_val` (1..256). Each `len_tick` with `len_en` high decrements a nonzero count, and reaching 0 clears `active`. A trigger with a count of 0 reloads 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Playback permit; low stops the voice |
| level | input | 2 | Output scaling code |
| rate | input | 11 | Rate value X, period 2*(2048-X) |
| trig | input | 1 | Restart pulse |
| len_en | input | 1 | Length counting permit |
| len_load | input | 1 | Load length count from len_val |
| len_val | input | 8 | Length field |
| len_tick | input | 1 | Length time-base tick |
| cpu_we | input | 1 | Table write strobe |
| cpu_addr | input | 4 | Table byte address |
| cpu_wdata | input | 8 | Table write data |
| cpu_rdata | output | 8 | Table read data (combinational) |
| sample | output | 4 | Scaled sample |
| active | output | 1 | Voice playing status |

## Verification
A trigger changes `active` and the pointer at the edge that samples it. Counting from that edge, the first fetch edge is P+3 edges later, and each following fetch edge is P edges after the previous one. The bench counts edges from each trigger and reads `sample` half a clock after the fetch edge. It also reads one cycle before the fetch edge to show that nothing changed early. The fetch-cycle window for `cpu_rdata`, for port writes and for table corruption is the cycle just before fetch edge k. That is edge P+2+(k-1)P after the trigger, and the bench drives its stimulus in exactly that cycle. Level changes and table reads are combinational and are checked 1 ns after the inputs change. Length and enable effects are checked half a clock after the edge that samples them.

// File: rtl/wavetable_voice.sv
module wavetable_voice #(
  parameter int RATE_W    = 11,
  parameter int LEN_W     = 8,
  parameter int START_DLY = 3,
  parameter int TBL_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        level,
  input  logic [RATE_W-1:0] rate,
  input  logic              trig,
  input  logic              len_en,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              len_tick,
  input  logic              cpu_we,
  input  logic [TBL_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [3:0]        sample,
  output logic              active
);
  localparam int NB = 1 << TBL_AW;
  localparam int PW = TBL_AW + 1;
  localparam int TW = RATE_W + 2;
  localparam int LW = LEN_W + 1;

  logic [7:0]        tbl [NB];
  logic [PW-1:0]     ptr;
  logic [7:0]        sbuf;
  logic [TW-1:0]     tmr;
  logic [LW-1:0]     lcnt;
  logic              act_q;

  wire [TW-1:0]     period  = TW'(2) * (TW'(2**RATE_W) - TW'(rate));
  wire              go      = trig && en;
  wire              fire    = act_q && (tmr == '0);
  wire [PW-1:0]     ptr_nx  = ptr + PW'(1);
  wire [TBL_AW-1:0] fidx    = ptr_nx[PW-1:1];
  wire [TBL_AW-1:0] cidx    = ptr[PW-1:1];
  wire [3:0]        nib     = ptr[0] ? sbuf[3:0] : sbuf[7:4];
  wire              len_hit = len_tick && len_en && (lcnt != '0);
  wire              len_end = len_hit && (lcnt == LW'(1));

  assign active    = act_q;
  assign sample    = (act_q && level != 2'd0) ? (nib >> (level - 2'd1)) : 4'd0;
  assign cpu_rdata = !act_q ? tbl[cpu_addr] : (fire ? tbl[fidx] : 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr   <= '0;
      sbuf  <= 8'h00;
      tmr   <= '0;
    end else begin
      if (!en)          act_q <= 1'b0;
      else if (go)      act_q <= 1'b1;
      else if (len_end) act_q <= 1'b0;

      if (go) begin
        ptr <= '0;
        tmr <= period + TW'(START_DLY - 1);
      end else if (fire) begin
        ptr  <= ptr_nx;
        sbuf <= tbl[fidx];
        tmr  <= period - TW'(1);
      end else if (act_q) begin
        tmr <= tmr - TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     lcnt <= '0;
    else if (len_load)              lcnt <= {1'b0, ~len_val} + LW'(1);
    else if (go && lcnt == '0)      lcnt <= LW'(2**LEN_W);
    else if (len_hit)               lcnt <= lcnt - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) tbl[i] <= 8'h00;
    end else begin
      if (cpu_we && (!act_q || fire))
        tbl[act_q ? fidx : cpu_addr] <= cpu_wdata;
      if (go && fire) begin
        if (cidx < TBL_AW'(4))
          tbl[0] <= sbuf;
        else
          for (int i = 0; i < 4; i++) tbl[i] <= tbl[{cidx[TBL_AW-1:2], i[1:0]}];
      end
    end
  end

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !act_q);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !go) |=> ptr == $past(ptr) + PW'(1));

  // R3
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(sbuf));

  // R9
  len_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !len_load && !len_hit) |=> lcnt != '0);

  // R2
  go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (act_q && ptr == '0));
endmodule

// File: tb/test_wavetable_voice.sv
module test_wavetable_voice;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] level = 2'd1;
  logic [10:0] rate = 11'd2044;
  logic trig = 1'b0, len_en = 1'b0, len_load = 1'b0, len_tick = 1'b0, cpu_we = 1'b0;
  logic [7:0] len_val = 8'd0;
  logic [3:0] cpu_addr = 4'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic [3:0] sample;
  logic active;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [16];

  always #4 clk = ~clk;

  wavetable_voice i_wavetable_voice (
    .clk(clk), .rst_n(rst_n), .en(en), .level(level), .rate(rate), .trig(trig),
    .len_en(len_en), .len_load(len_load), .len_val(len_val), .len_tick(len_tick),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sample(sample), .active(active));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; step(1); trig = 1'b0;
  endtask

  task automatic readback(string req, int idx);
    cpu_addr = 4'(idx); #1;
    chk(req, cpu_rdata, mdl[idx]);
  endtask

  task automatic t_reset();
    chk("R1 active", {7'd0, active}, 8'd0);
    chk("R1 sample", {4'd0, sample}, 8'd0);
    cpu_addr = 4'd7; #1;
    chk("R1 table", cpu_rdata, 8'h00);
  endtask

  task automatic t_cpu_off();
    for (int i = 0; i < 16; i++) begin
      mdl[i] = {4'(i), 4'(15 - i)};
      cpu_addr = 4'(i); cpu_wdata = mdl[i]; cpu_we = 1'b1; step(1);
    end
    cpu_we = 1'b0;
    readback("R6 byte 3", 3);
    readback("R6 byte 12", 12);
  endtask

  task automatic t_stale();
    en = 1'b1; level = 2'd1;
    pulse_trig();
    chk("R2 active after trigger", {7'd0, active}, 8'd1);
    chk("R3 stale nibble", {4'd0, sample}, 8'h0);
    step(P + 2);
    chk("R2 no early fetch", {4'd0, sample}, 8'h0);
    step(1);
    chk("R3 first fetch low nibble byte0", {4'd0, sample}, 8'h0F);
    step(P - 1);
    chk("R2 hold between fetches", {4'd0, sample}, 8'h0F);
    step(1);
    chk("R2 second fetch", {4'd0, sample}, 8'h01);
    step(P);
    chk("R2 third fetch", {4'd0, sample}, 8'h0E);
    en = 1'b0; step(1);
    chk("R5 disabled", {7'd0, active}, 8'd0);
    chk("R5 muted", {4'd0, sample}, 8'd0);
    en = 1'b1;
    pulse_trig();
    chk("R3 stale buffer 0x1E upper", {4'd0, sample}, 8'h01);
  endtask

  task automatic t_level();
    step(P + 3);
    chk("R4 level1", {4'd0, sample}, 8'h0F);
    level = 2'd2; #1;
    chk("R4 level2", {4'd0, sample}, 8'h07);
    level = 2'd3; #1;
    chk("R4 level3", {4'd0, sample}, 8'h03);
    level = 2'd0; #1;
    chk("R4 level0 mute", {4'd0, sample}, 8'h00);
    chk("R4 level0 still active", {7'd0, active}, 8'd1);
    level = 2'd1;
  endtask

  task automatic t_cpu_on();
    pulse_trig();
    step(3);
    cpu_addr = 4'd5; #1;
    chk("R7 read outside fetch", cpu_rdata, 8'hFF);
    cpu_wdata = 8'hAA; cpu_we = 1'b1; step(1); cpu_we = 1'b0;
    step(P + 2 - 4);
    cpu_addr = 4'd9; #1;
    chk("R7 read in fetch", cpu_rdata, mdl[0]);
    cpu_wdata = 8'h55; cpu_we = 1'b1; step(1); cpu_we = 1'b0;
    mdl[0] = 8'h55;
  endtask

  task automatic t_corrupt();
    logic [7:0] saved;
    pulse_trig();
    step(P + 2 + 20 * P);
    saved = mdl[10];
    pulse_trig();
    for (int i = 0; i < 4; i++) mdl[i] = mdl[8 + i];
    chk("R8 still active", {7'd0, active}, 8'd1);
    step(P + 2);
    pulse_trig();
    mdl[0] = saved;
    en = 1'b0; step(1);
    readback("R8 byte0 from buffer", 0);
    readback("R8 byte1 from group", 1);
    readback("R8 byte2 from group", 2);
    readback("R8 byte3 from group", 3);
    readback("R7 dropped write byte5", 5);
  endtask

  task automatic t_len();
    en = 1'b1;
    len_val = 8'd253; len_load = 1'b1; step(1); len_load = 1'b0;
    pulse_trig();
    len_tick = 1'b1; step(5); len_tick = 1'b0;
    chk("R9 ticks ignored when disabled", {7'd0, active}, 8'd1);
    len_en = 1'b1;
    len_tick = 1'b1; step(2); len_tick = 1'b0;
    chk("R9 active before expiry", {7'd0, active}, 8'd1);
    len_tick = 1'b1; step(1); len_tick = 1'b0;
    chk("R9 expired after 3", {7'd0, active}, 8'd0);
    pulse_trig();
    len_tick = 1'b1; step(255); len_tick = 1'b0;
    chk("R9 reload 256 active at 255", {7'd0, active}, 8'd1);
    len_tick = 1'b1; step(1); len_tick = 1'b0;
    chk("R9 reload 256 expired", {7'd0, active}, 8'd0);
    len_en = 1'b0;
  endtask

  task automatic t_gate();
    en = 1'b0;
    pulse_trig();
    chk("R5 trigger ignored", {7'd0, active}, 8'd0);
    cpu_addr = 4'd4; cpu_wdata = 8'h3C; cpu_we = 1'b1; step(1); cpu_we = 1'b0;
    mdl[4] = 8'h3C;
    readback("R6 write while idle", 4);
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cpu_off();
    t_stale();
    t_level();
    t_cpu_on();
    t_corrupt();
    t_len();
    t_gate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule